// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

A byte-wide mailbox between a host I/O bus and an embedded controller. The host sees two I/O addresses: a data address that moves bytes in both directions, and a command address that accepts command bytes on write and returns a two-flag status byte on read. Every host write that finds the inbound slot empty latches the byte, marks the slot full and records whether the byte arrived as a command or as data. Every controller write to its data register fills the outbound slot, and a host read of the data address empties it.

The controller reaches three registers through a 2-bit select: a configuration register holding two interrupt enables, a control/status register that shows both flags and the command/data tag and accepts write-one clear codes, and a data register that returns the latched host byte on read and loads the outbound byte on write. Two interrupt outputs pulse for one cycle: one when the inbound slot fills, one when the host empties the outbound slot. Each has its own enable. A typical controller handler clears a stale outbound byte before it releases the inbound slot. Because the host polls both flags together, it cannot then pick up leftover data from an abandoned command.

Top module: `host_ec_mailbox`

## Requirements
- R1: After reset, both flags, the command/data tag, both interrupt enables and both interrupt outputs are 0.
- R2: A host write to the data address (default 0x68) or the command address (default 0x6c) while inbound-full is 0 latches the byte and sets inbound-full. It also sets the tag, which is control/status bit 6: 1 for the command address, 0 for the data address.
- R3: A host write while inbound-full is 1 is ignored. The latched byte and the tag keep their values.
- R4: A host read of the command address returns outbound-full in bit 0, inbound-full in bit 1 and 0 in bits 7..2.
- R5: A controller write with select 2 (data) loads the outbound byte and sets outbound-full. A host read of the data address returns that byte and clears outbound-full.
- R6: A controller write with select 1 (control/status) clears outbound-full when data bit 0 is 1 (code 0x01) and clears inbound-full when data bit 1 is 1 (code 0x02). A 0 bit leaves its flag as it is.
- R7: Controller reads return values as follows. Select 1 gives outbound-full in bit 0, inbound-full in bit 1 and the tag in bit 6, with all other bits 0. Select 2 gives the latched host byte. Select 0 gives the two enables in bits 1..0. Select 3 gives 0.
- R8: The inbound interrupt is a one-cycle pulse in the first cycle that inbound-full reads 1. It fires only when configuration bit 1 is set.
- R9: The outbound interrupt is a one-cycle pulse in the first cycle after a host data read that found outbound-full at 1. It fires only when configuration bit 0 is set. A host data read while outbound-full is 0 gives no pulse.
- R10: Host accesses to any other address change no state, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | ADDR_W | Host I/O address |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte, valid while h_rd is high |
| c_sel | input | 2 | Controller register select: 0 config, 1 control/status, 2 data |
| c_wr | input | 1 | Controller write strobe |
| c_rd | input | 1 | Controller read strobe |
| c_wdata | input | 8 | Controller write byte |
| c_rdata | output | 8 | Controller read byte |
| irq_in_full | output | 1 | Pulse when the inbound slot fills |
| irq_out_empty | output | 1 | Pulse when the host empties the outbound slot |

## Verification
On every cycle, the assertions check four things: each interrupt pulse corresponds to the flag edge that caused it and to its enable; a rejected host write leaves the latched byte and tag untouched; the clear codes take effect on the next cycle; and the unused status bits stay 0. Some behaviour only the bench's scenarios can show. This covers the byte values carried end to end, the command/data tag for each address, the masking of each interrupt by its enable, and the silence of unmapped addresses. It also covers the handler ordering in which a stale outbound byte is dropped before the inbound slot is released.

// File: rtl/host_ec_mailbox.sv
module host_ec_mailbox #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] DATA_ADDR = 16'h0068,
  parameter logic [15:0] CMD_ADDR  = 16'h006C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [7:0]        h_wdata,
  output logic [7:0]        h_rdata,
  input  logic [1:0]        c_sel,
  input  logic              c_wr,
  input  logic              c_rd,
  input  logic [7:0]        c_wdata,
  output logic [7:0]        c_rdata,
  output logic              irq_in_full,
  output logic              irq_out_empty
);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);
  localparam logic [1:0] SEL_CFG = 2'd0;
  localparam logic [1:0] SEL_CSR = 2'd1;
  localparam logic [1:0] SEL_DAT = 2'd2;

  logic       in_full, out_full, tag_cmd;
  logic [1:0] irq_en;
  logic [7:0] in_byte, out_byte;

  logic hit_data, hit_cmd, host_take, host_drain;
  logic c_wr_cfg, c_wr_csr, c_wr_dat;

  assign hit_data   = (h_addr == DATA_A);
  assign hit_cmd    = (h_addr == CMD_A);
  assign host_take  = h_wr && (hit_data || hit_cmd) && !in_full;
  assign host_drain = h_rd && hit_data && out_full;

  assign c_wr_cfg = c_wr && (c_sel == SEL_CFG);
  assign c_wr_csr = c_wr && (c_sel == SEL_CSR);
  assign c_wr_dat = c_wr && (c_sel == SEL_DAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_full  <= 1'b0;
      tag_cmd  <= 1'b0;
      in_byte  <= 8'h00;
    end else if (host_take) begin
      in_full  <= 1'b1;
      tag_cmd  <= hit_cmd;
      in_byte  <= h_wdata;
    end else if (c_wr_csr && c_wdata[1]) begin
      in_full  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_full <= 1'b0;
      out_byte <= 8'h00;
    end else if (c_wr_dat) begin
      out_full <= 1'b1;
      out_byte <= c_wdata;
    end else if (host_drain || (c_wr_csr && c_wdata[0])) begin
      out_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_en <= 2'b00;
    else if (c_wr_cfg) irq_en <= c_wdata[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_in_full   <= 1'b0;
      irq_out_empty <= 1'b0;
    end else begin
      irq_in_full   <= host_take  && irq_en[1];
      irq_out_empty <= host_drain && irq_en[0];
    end
  end

  always_comb begin
    h_rdata = 8'h00;
    if (h_rd && hit_data)     h_rdata = out_byte;
    else if (h_rd && hit_cmd) h_rdata = {6'b0, in_full, out_full};
  end

  always_comb begin
    unique case (c_sel)
      SEL_CFG: c_rdata = {6'b0, irq_en};
      SEL_CSR: c_rdata = {1'b0, tag_cmd, 4'b0, in_full, out_full};
      SEL_DAT: c_rdata = in_byte;
      default: c_rdata = 8'h00;
    endcase
  end
endmodule

module host_ec_mailbox_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] CMD_ADDR = 16'h006C
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] h_addr,
  input logic              h_wr,
  input logic              h_rd,
  input logic [7:0]        h_rdata,
  input logic [1:0]        c_sel,
  input logic              c_wr,
  input logic [7:0]        c_wdata,
  input logic              in_full,
  input logic              out_full,
  input logic              tag_cmd,
  input logic [7:0]        in_byte,
  input logic [1:0]        irq_en,
  input logic              irq_in_full,
  input logic              irq_out_empty
);
  assert_in_irq_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in_full |-> (in_full && !$past(in_full) && $past(irq_en[1])));

  assert_out_irq_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out_empty |-> ($past(out_full) && $past(h_rd) && $past(irq_en[0])));

  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_full && h_wr && !(c_wr && c_sel == 2'd1 && c_wdata[1]))
      |=> (in_full && $stable(in_byte) && $stable(tag_cmd)));

  assert_clear_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_full && c_wr && c_sel == 2'd1 && c_wdata[1]) |=> !in_full);

  assert_clear_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && c_sel == 2'd1 && c_wdata[0] && !(c_wr && c_sel == 2'd2)) |=> !out_full);

  assert_status_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_addr == ADDR_W'(CMD_ADDR)) |-> (h_rdata[7:2] == 6'b0));
endmodule

bind host_ec_mailbox host_ec_mailbox_chk #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
  .h_rdata(h_rdata), .c_sel(c_sel), .c_wr(c_wr), .c_wdata(c_wdata),
  .in_full(in_full), .out_full(out_full), .tag_cmd(tag_cmd), .in_byte(in_byte),
  .irq_en(irq_en), .irq_in_full(irq_in_full), .irq_out_empty(irq_out_empty)
);

// File: tb/test_host_ec_mailbox.sv
module test_host_ec_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] h_addr = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0]  h_wdata = '0, h_rdata;
  logic [1:0]  c_sel = '0;
  logic        c_wr = 1'b0, c_rd = 1'b0;
  logic [7:0]  c_wdata = '0, c_rdata;
  logic        irq_in_full, irq_out_empty;

  int n_cmp = 0, n_bad = 0;
  localparam logic [15:0] DA = 16'h0068, CA = 16'h006C;

  always #2.5 clk = ~clk;

  host_ec_mailbox i_host_ec_mailbox (
    .clk, .rst_n, .h_addr, .h_wr, .h_rd, .h_wdata, .h_rdata,
    .c_sel, .c_wr, .c_rd, .c_wdata, .c_rdata, .irq_in_full, .irq_out_empty
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hrd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); h_addr = a; h_rd = 1'b1; #1 d = h_rdata;
    @(negedge clk); h_rd = 1'b0;
  endtask

  task automatic cwr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); c_sel = s; c_wdata = d; c_wr = 1'b1;
    @(negedge clk); c_wr = 1'b0;
  endtask

  task automatic crd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); c_sel = s; c_rd = 1'b1; #1 d = c_rdata;
    @(negedge clk); c_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    crd(2'd1, v); chk(v == 8'h00, "R1 csr", v, 0);
    crd(2'd0, v); chk(v == 8'h00, "R1 cfg", v, 0);
    chk(!irq_in_full && !irq_out_empty, "R1 irqs", {irq_in_full, irq_out_empty}, 0);
    hrd(CA, v); chk(v == 8'h00, "R4 idle status", v, 0);
  endtask

  task automatic t_command_in;
    logic [7:0] v;
    cwr(2'd0, 8'h02);
    hwr(CA, 8'hA5);
    chk(irq_in_full, "R8 pulse", irq_in_full, 1);
    @(negedge clk); chk(!irq_in_full, "R8 single cycle", irq_in_full, 0);
    crd(2'd1, v); chk(v == 8'h42, "R2 R7 csr cmd tag", v, 8'h42);
    crd(2'd2, v); chk(v == 8'hA5, "R7 latched byte", v, 8'hA5);
    hrd(CA, v); chk(v == 8'h02, "R4 in-full status", v, 2);
    hwr(DA, 8'h11);
    chk(!irq_in_full, "R3 no pulse", irq_in_full, 0);
    crd(2'd2, v); chk(v == 8'hA5, "R3 byte kept", v, 8'hA5);
    crd(2'd1, v); chk(v == 8'h42, "R3 tag kept", v, 8'h42);
    cwr(2'd1, 8'h02);
    crd(2'd1, v); chk(v == 8'h40, "R6 clear in-full", v, 8'h40);
  endtask

  task automatic t_data_in;
    logic [7:0] v;
    cwr(2'd0, 8'h00);
    hwr(DA, 8'h3C);
    chk(!irq_in_full, "R8 masked", irq_in_full, 0);
    crd(2'd1, v); chk(v == 8'h02, "R2 data tag", v, 2);
    crd(2'd2, v); chk(v == 8'h3C, "R2 data byte", v, 8'h3C);
    cwr(2'd1, 8'h02);
  endtask

  task automatic t_data_out;
    logic [7:0] v;
    cwr(2'd0, 8'h01);
    cwr(2'd2, 8'h5A);
    hrd(CA, v); chk(v == 8'h01, "R4 out-full status", v, 1);
    crd(2'd1, v); chk(v[1:0] == 2'b01, "R7 csr out-full", v, 1);
    hrd(DA, v); chk(v == 8'h5A, "R5 host reads byte", v, 8'h5A);
    chk(irq_out_empty, "R9 pulse", irq_out_empty, 1);
    @(negedge clk); chk(!irq_out_empty, "R9 single cycle", irq_out_empty, 0);
    hrd(CA, v); chk(v == 8'h00, "R5 out-full cleared", v, 0);
    hrd(DA, v);
    chk(!irq_out_empty, "R9 no pulse when empty", irq_out_empty, 0);
    cwr(2'd0, 8'h00);
    cwr(2'd2, 8'h77);
    hrd(DA, v);
    chk(!irq_out_empty, "R9 masked", irq_out_empty, 0);
  endtask

  task automatic t_stale_drop;
    logic [7:0] v;
    cwr(2'd2, 8'hEE);
    hwr(CA, 8'h81);
    hrd(CA, v); chk(v == 8'h03, "R4 both flags", v, 3);
    cwr(2'd1, 8'h01);
    hrd(CA, v); chk(v == 8'h02, "R6 clear out-full only", v, 2);
    cwr(2'd1, 8'h00);
    hrd(CA, v); chk(v == 8'h02, "R6 zero code no effect", v, 2);
    cwr(2'd1, 8'h02);
    hrd(CA, v); chk(v == 8'h00, "R6 clear in-full", v, 0);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    cwr(2'd2, 8'h99);
    hwr(16'h0060, 8'h12);
    crd(2'd1, v); chk(v[1] == 1'b0, "R10 write ignored", v, 1);
    hrd(16'h0064, v); chk(v == 8'h00, "R10 read zero", v, 0);
    hrd(CA, v); chk(v == 8'h01, "R10 out-full kept", v, 1);
    crd(2'd3, v); chk(v == 8'h00, "R7 select 3", v, 0);
    cwr(2'd1, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_command_in();
    t_data_in();
    t_data_out();
    t_stale_drop();
    t_unmapped();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule